// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic stage of a small accumulator-style processor core. Each accepted operation combines the working register value with either a file-register value or an 8-bit literal. It covers add, add with carry, four subtraction forms, increment, decrement, one's complement and two's-complement negate. The block registers the 8-bit result, a destination indicator and five status flags, and presents them one clock after the operation is accepted.

The flag register holds its state between operations, so the carry left by one operation feeds the next one. This lets a program chain wide additions and subtractions byte by byte. Subtraction uses a carry-as-not-borrow convention: C=1 after a subtraction means no borrow occurred. The borrow consumed by the borrow-aware forms is the inverse of the stored C. Register storage, instruction fetch and banking sit outside this block.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `result`, `result_valid`, `to_file` and all five flags to 0 at that edge.
- R2: An operation with `op_valid`=1 and a defined code (0 to 10) produces its result, destination and flags at the next rising edge, with `result_valid` high for that one cycle.
- R3: The add codes are: 0 gives W+literal, 1 gives W+F, and 2 gives W+F+C, where C is the stored carry. For example, 0x1F+0x72 with C=1 gives 0x92.
- R4: The subtract codes are: 3 gives literal−W, 4 gives F−W, 5 gives W−F−(1−C), and 6 gives F−W−(1−C). After a subtraction, C=1 means no borrow and DC=1 means no borrow out of the low nibble.
- R5: Code 7 gives F+1 and code 8 gives F−1. Both update all five flags, exactly as an add or subtract of one would.
- R6: Code 9 gives the bitwise inverse of F. It updates only N and Z, and OV, DC and C keep their values.
- R7: Code 10 gives 0−F (two's complement) and updates all five flags. For example, F=0x80 gives 0x80 with OV=1, and F=0x00 gives 0x00 with C=1 and Z=1.
- R8: The flags are defined as follows. N is result bit 7. Z means the result is zero. DC is the carry out of bit 3. C is the carry out of bit 7. OV is two's-complement overflow. For example, 0x4F+0x48 gives 0x97 with N=1, OV=1, Z=0, DC=1 and C=0.
- R9: For codes 1, 2 and 4 to 9, `to_file` equals `dest_sel`, where 0 selects the working register and 1 selects the file register. Codes 0 and 3 always give `to_file`=0. Code 10 always gives `to_file`=1.
- R10: A cycle with `op_valid`=0, or with an undefined code (11 to 15), leaves `result`, `to_file` and all flags unchanged and drives `result_valid` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation select, codes 0 to 10 |
| dest_sel | input | 1 | Destination request: 0 working register, 1 file register |
| wreg_in | input | 8 | Working register value |
| freg_in | input | 8 | File register value |
| lit_in | input | 8 | Literal operand |
| result | output | 8 | Registered result |
| result_valid | output | 1 | Result produced by the previous cycle's operation |
| to_file | output | 1 | Result is to be written to the file register |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_dc | output | 1 | Digit carry, the nibble carry out of bit 3 |
| flag_c | output | 1 | Carry, or not-borrow after a subtraction |

## Verification
The bench targets the borrow convention, which a design gets wrong by inverting C after subtraction. That error would break chained subtraction of 0x00−0x01 style operands. It covers the two-byte add chain, where a carry that is ignored turns 0x92 into 0x91. It probes negate of 0x80 and 0x00, where a wrong overflow or carry rule shows up at once. It also checks that complement keeps C, DC and OV, which a design that routes complement through the full flag path would clear. Decrement of 0x80 and 0x00, increment of 0xFF, and the fixed destinations of the literal and negate codes are also checked, while randomized operations cover the rest.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_LIT = 4'd0,
    OP_ADD_F   = 4'd1,
    OP_ADC_F   = 4'd2,
    OP_SUB_LIT = 4'd3,
    OP_SUB_F   = 4'd4,
    OP_SBB_WF  = 4'd5,
    OP_SBB_FW  = 4'd6,
    OP_INC_F   = 4'd7,
    OP_DEC_F   = 4'd8,
    OP_COM_F   = 4'd9,
    OP_NEG_F   = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } alu_flags_t;

  // destination policy for an operation
  typedef enum logic [1:0] {
    DST_REQ  = 2'd0,
    DST_WREG = 2'd1,
    DST_FILE = 2'd2
  } dst_mode_e;

  function automatic logic op_defined(input logic [3:0] code);
    return code <= OP_NEG_F;
  endfunction

endpackage

// File: rtl/balu_operand_sel.sv
module balu_operand_sel
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] wreg_in,
  input  logic [WIDTH-1:0] freg_in,
  input  logic [WIDTH-1:0] lit_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] opa,
  output logic [WIDTH-1:0] opb,
  output logic             cin,
  output logic             nz_only,
  output dst_mode_e        dst_mode
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONES = '1;

  // every operation is expressed as opa + opb + cin;
  // subtraction x - y uses x + ~y + (not borrow)
  always_comb begin
    opa      = ZERO;
    opb      = ZERO;
    cin      = 1'b0;
    nz_only  = 1'b0;
    dst_mode = DST_REQ;
    case (alu_op_e'(op_code))
      OP_ADD_LIT: begin
        opa = wreg_in; opb = lit_in; dst_mode = DST_WREG;
      end
      OP_ADD_F: begin
        opa = wreg_in; opb = freg_in;
      end
      OP_ADC_F: begin
        opa = wreg_in; opb = freg_in; cin = carry_in;
      end
      OP_SUB_LIT: begin
        opa = lit_in; opb = ~wreg_in; cin = 1'b1; dst_mode = DST_WREG;
      end
      OP_SUB_F: begin
        opa = freg_in; opb = ~wreg_in; cin = 1'b1;
      end
      OP_SBB_WF: begin
        opa = wreg_in; opb = ~freg_in; cin = carry_in;
      end
      OP_SBB_FW: begin
        opa = freg_in; opb = ~wreg_in; cin = carry_in;
      end
      OP_INC_F: begin
        opa = freg_in; opb = ZERO; cin = 1'b1;
      end
      OP_DEC_F: begin
        opa = freg_in; opb = ONES; cin = 1'b0;
      end
      OP_COM_F: begin
        opa = ~freg_in; nz_only = 1'b1;
      end
      OP_NEG_F: begin
        opa = ZERO; opb = ~freg_in; cin = 1'b1; dst_mode = DST_FILE;
      end
      default: begin
        opa = ZERO;
      end
    endcase
  end

endmodule

// File: rtl/balu_adder.sv
module balu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             nib_carry,
  output logic             overflow
);

  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  logic [LO:0] lo_sum;
  logic [HI:0] hi_sum;

  // split at the nibble boundary so the digit carry is a real wire
  always_comb begin
    lo_sum = {1'b0, opa[LO-1:0]} + {1'b0, opb[LO-1:0]} + {{LO{1'b0}}, cin};
    hi_sum = {1'b0, opa[WIDTH-1:LO]} + {1'b0, opb[WIDTH-1:LO]}
           + {{HI{1'b0}}, lo_sum[LO]};
    sum       = {hi_sum[HI-1:0], lo_sum[LO-1:0]};
    carry_out = hi_sum[HI];
    nib_carry = lo_sum[LO];
    overflow  = (opa[WIDTH-1] == opb[WIDTH-1]) && (sum[WIDTH-1] != opa[WIDTH-1]);
  end

endmodule

// File: rtl/balu_flag_eval.sv
module balu_flag_eval
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             carry_out,
  input  logic             nib_carry,
  input  logic             overflow,
  input  logic             nz_only,
  input  alu_flags_t       cur_flags,
  output alu_flags_t       nxt_flags
);

  always_comb begin
    nxt_flags.n  = sum[WIDTH-1];
    nxt_flags.z  = (sum == '0);
    nxt_flags.ov = nz_only ? cur_flags.ov : overflow;
    nxt_flags.dc = nz_only ? cur_flags.dc : nib_carry;
    nxt_flags.c  = nz_only ? cur_flags.c  : carry_out;
  end

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic             dest_sel,
  input  logic [WIDTH-1:0] wreg_in,
  input  logic [WIDTH-1:0] freg_in,
  input  logic [WIDTH-1:0] lit_in,
  output logic [WIDTH-1:0] result,
  output logic             result_valid,
  output logic             to_file,
  output logic             flag_n,
  output logic             flag_ov,
  output logic             flag_z,
  output logic             flag_dc,
  output logic             flag_c
);

  alu_flags_t       flags_q;
  alu_flags_t       flags_d;
  logic [WIDTH-1:0] opa, opb, sum;
  logic             cin, nz_only, carry_out, nib_carry, overflow;
  dst_mode_e        dst_mode;
  logic             accept;
  logic             dest_d;

  balu_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .op_code  (op_code),
    .wreg_in  (wreg_in),
    .freg_in  (freg_in),
    .lit_in   (lit_in),
    .carry_in (flags_q.c),
    .opa      (opa),
    .opb      (opb),
    .cin      (cin),
    .nz_only  (nz_only),
    .dst_mode (dst_mode)
  );

  balu_adder #(.WIDTH(WIDTH)) u_add (
    .opa       (opa),
    .opb       (opb),
    .cin       (cin),
    .sum       (sum),
    .carry_out (carry_out),
    .nib_carry (nib_carry),
    .overflow  (overflow)
  );

  balu_flag_eval #(.WIDTH(WIDTH)) u_flags (
    .sum       (sum),
    .carry_out (carry_out),
    .nib_carry (nib_carry),
    .overflow  (overflow),
    .nz_only   (nz_only),
    .cur_flags (flags_q),
    .nxt_flags (flags_d)
  );

  assign accept = op_valid && op_defined(op_code);

  always_comb begin
    case (dst_mode)
      DST_WREG: dest_d = 1'b0;
      DST_FILE: dest_d = 1'b1;
      default:  dest_d = dest_sel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
      to_file      <= 1'b0;
      flags_q      <= '0;
    end else begin
      result_valid <= accept;
      if (accept) begin
        result  <= sum;
        to_file <= dest_d;
        flags_q <= flags_d;
      end
    end
  end

  assign flag_n  = flags_q.n;
  assign flag_ov = flags_q.ov;
  assign flag_z  = flags_q.z;
  assign flag_dc = flags_q.dc;
  assign flag_c  = flags_q.c;

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic             dest_sel,
  input logic [WIDTH-1:0] wreg_in,
  input logic [WIDTH-1:0] freg_in,
  input logic [WIDTH-1:0] lit_in,
  input logic [WIDTH-1:0] result,
  input logic             result_valid,
  input logic             to_file,
  input logic             flag_n,
  input logic             flag_ov,
  input logic             flag_z,
  input logic             flag_dc,
  input logic             flag_c
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !result_valid && !to_file &&
             !flag_n && !flag_ov && !flag_z && !flag_dc && !flag_c));

  assert_next_cycle_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_defined(op_code)) |=> result_valid);

  assert_add_lit_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD_LIT) |=> result == $past(wreg_in + lit_in));

  assert_add_file_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD_F) |=> result == $past(wreg_in + freg_in));

  assert_no_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SUB_F && freg_in >= wreg_in) |=> flag_c);

  assert_com_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_COM_F) |=>
      ($stable(flag_c) && $stable(flag_dc) && $stable(flag_ov)));

  assert_neg_to_file_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_NEG_F) |=> to_file);

  assert_nz_match_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (flag_n == result[WIDTH-1] && flag_z == (result == '0)));

  assert_lit_to_wreg_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_ADD_LIT || op_code == OP_SUB_LIT)) |=> !to_file);

  assert_dest_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= OP_SUB_F && op_code <= OP_COM_F) |=> to_file == $past(dest_sel));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || !op_defined(op_code)) |=>
      (!result_valid && $stable(result) && $stable(to_file) &&
       $stable(flag_n) && $stable(flag_ov) && $stable(flag_z) &&
       $stable(flag_dc) && $stable(flag_c)));

endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .dest_sel     (dest_sel),
  .wreg_in      (wreg_in),
  .freg_in      (freg_in),
  .lit_in       (lit_in),
  .result       (result),
  .result_valid (result_valid),
  .to_file      (to_file),
  .flag_n       (flag_n),
  .flag_ov      (flag_ov),
  .flag_z       (flag_z),
  .flag_dc      (flag_dc),
  .flag_c       (flag_c)
);

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic       dest_sel = 1'b0;
  logic [7:0] wreg_in = '0, freg_in = '0, lit_in = '0;
  logic [7:0] result;
  logic       result_valid, to_file;
  logic       flag_n, flag_ov, flag_z, flag_dc, flag_c;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // model state: {to_file, n, ov, z, dc, c, result}
  logic [13:0] m_state = '0;

  always #2.5 clk = ~clk;

  byte_alu u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dest_sel(dest_sel), .wreg_in(wreg_in), .freg_in(freg_in), .lit_in(lit_in),
    .result(result), .result_valid(result_valid), .to_file(to_file),
    .flag_n(flag_n), .flag_ov(flag_ov), .flag_z(flag_z),
    .flag_dc(flag_dc), .flag_c(flag_c)
  );

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] w,
                                        input logic [7:0] f, input logic [7:0] l,
                                        input logic d, input logic [13:0] prev);
    int x, y, k, r, sr;
    logic is_add;
    logic [7:0] res;
    logic n, ov, z, dc, c, tf;
    logic c_old;
    c_old = prev[8];
    ov = prev[11]; dc = prev[9]; c = prev[8];
    x = 0; y = 0; k = 0; is_add = 1'b1;
    case (op)
      4'd0: begin x = w; y = l; end
      4'd1: begin x = w; y = f; end
      4'd2: begin x = w; y = f; k = c_old; end
      4'd3: begin is_add = 0; x = l; y = w; end
      4'd4: begin is_add = 0; x = f; y = w; end
      4'd5: begin is_add = 0; x = w; y = f; k = !c_old; end
      4'd6: begin is_add = 0; x = f; y = w; k = !c_old; end
      4'd7: begin x = f; y = 1; end
      4'd8: begin is_add = 0; x = f; y = 1; end
      4'd10: begin is_add = 0; x = 0; y = f; end
      default: ;
    endcase
    if (op == 4'd9) begin
      res = ~f;
    end else if (is_add) begin
      r = x + y + k; res = r[7:0];
      c = (r > 255); dc = ((x % 16) + (y % 16) + k) > 15;
      sr = sgn(x) + sgn(y) + k; ov = (sr > 127) || (sr < -128);
    end else begin
      r = x - y - k; res = r[7:0];
      c = (x >= y + k); dc = ((x % 16) >= (y % 16) + k);
      sr = sgn(x) - sgn(y) - k; ov = (sr > 127) || (sr < -128);
    end
    n = res[7]; z = (res == 8'h00);
    tf = (op == 4'd0 || op == 4'd3) ? 1'b0 : (op == 4'd10) ? 1'b1 : d;
    return {tf, n, ov, z, dc, c, res};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd2) return "R3 R2 R8 R9";
    if (op <= 4'd6) return "R4 R2 R8 R9";
    if (op <= 4'd8) return "R5 R2 R8 R9";
    if (op == 4'd9) return "R6 R2 R9";
    if (op == 4'd10) return "R7 R2 R8 R9";
    return "R10";
  endfunction

  task automatic compare(input string tag, input logic exp_valid);
    logic [14:0] act, exp;
    act = {result_valid, to_file, flag_n, flag_ov, flag_z, flag_dc, flag_c, result};
    exp = {exp_valid, m_state};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got vld/tf/n/ov/z/dc/c/res=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(input logic v, input logic [3:0] op, input logic [7:0] w,
                        input logic [7:0] f, input logic [7:0] l, input logic d);
    logic defd;
    op_valid = v; op_code = op; wreg_in = w; freg_in = f; lit_in = l; dest_sel = d;
    defd = v && (op <= 4'd10);
    if (defd) m_state = model(op, w, f, l, d, m_state);
    @(negedge clk);
    compare(defd ? tag_of(op) : "R10", defd);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with busy inputs
    op_valid = 1'b1; op_code = 4'd1; wreg_in = 8'hFF; freg_in = 8'h01;
    repeat (3) @(negedge clk);
    compare("R1", 1'b0);
    rst = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);

    // R8: documented example, DC and OV set, no carry
    run_op(1, 4'd1, 8'h4F, 8'h48, 8'h00, 0);
    if (result !== 8'h97 || {flag_n, flag_ov, flag_z, flag_dc, flag_c} !== 5'b11010) begin
      n_errors++; $display("FAIL R8: res=%h flags=%b exp 97 11010", result,
                           {flag_n, flag_ov, flag_z, flag_dc, flag_c});
    end
    n_checks++;
    // R3: two-byte chain 0x1F91 + 0x7292
    run_op(1, 4'd1, 8'h91, 8'h92, 8'h00, 0);
    run_op(1, 4'd2, 8'h1F, 8'h72, 8'h00, 0);
    n_checks++;
    if (result !== 8'h92) begin
      n_errors++; $display("FAIL R3: chained high byte=%h exp 92", result);
    end
    // R4: subtraction chain with borrow, 0x0100 - 0x0001
    run_op(1, 4'd4, 8'h01, 8'h00, 8'h00, 1);
    run_op(1, 4'd6, 8'h00, 8'h01, 8'h00, 1);
    run_op(1, 4'd3, 8'h10, 8'h00, 8'h05, 1);
    run_op(1, 4'd5, 8'h00, 8'h01, 8'h00, 0);
    // R5: wrap corners
    run_op(1, 4'd7, 8'h00, 8'hFF, 8'h00, 1);
    run_op(1, 4'd8, 8'h00, 8'h00, 8'h00, 0);
    run_op(1, 4'd8, 8'h00, 8'h80, 8'h00, 1);
    run_op(1, 4'd7, 8'h00, 8'h7F, 8'h00, 0);
    // R6: complement after carry set keeps C/DC/OV
    run_op(1, 4'd1, 8'hFF, 8'hFF, 8'h00, 0);
    run_op(1, 4'd9, 8'h00, 8'hFF, 8'h00, 1);
    // R7: negate corners, destination forced to file
    run_op(1, 4'd10, 8'h00, 8'h80, 8'h00, 0);
    run_op(1, 4'd10, 8'h00, 8'h00, 8'h00, 0);
    run_op(1, 4'd10, 8'h00, 8'h01, 8'h00, 0);
    // R10: idle and undefined codes
    run_op(0, 4'd1, 8'h12, 8'h34, 8'h00, 1);
    run_op(1, 4'd13, 8'h12, 8'h34, 8'h00, 1);
    run_op(1, 4'd15, 8'hAA, 8'h55, 8'h00, 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 11);
      run_op(($urandom % 10) != 0, op, 8'($urandom), 8'($urandom),
             8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: got running, exp finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule